// File: doc/BRIEF.md
# Output Engine Trigger and Gate Conditioner

This block conditions the three timing controls of a timed digital output engine: the start trigger, the update clock and the external gate. Each control has a 6-bit selector that picks one of 64 routed input lines. Routed lines are asynchronous to the engine clock, so they pass through a two-flop synchronizer bank before any selection or edge logic. Two selector codes have fixed meanings. Code 31 is a constant low on every path. Code 0 means something different on each path: the software start pulse for start, the internal timer's terminal count for update, and "gating off" for the gate.

Each path has a polarity control. The start path can run in edge mode, where it produces a single-cycle pulse on the active edge, or in level mode, where it follows the polarity-adjusted level. The update path is either internal or external. In internal mode each terminal-count cycle becomes an update pulse and the polarity control is ignored. In external mode the active edge of the routed line gives one pulse. While the gate is inactive, update pulses are suppressed. Start pulses are not affected by the gate.

Top module: `dout_trig_cond`

## Requirements
- R1: While reset is asserted, and just after it, `start_pulse` and `update_pulse` are 0 and `gate_ok` is 1.
- R2: With `start_edge`=1, `start_pol`=0 and a routed start select (not 0 or 31), a rising edge on the selected `route_in` line gives a `start_pulse` of exactly one cycle. The pulse appears after the third rising clock edge that follows the input change. Holding the line high gives no further pulse.
- R3: With `start_pol`=1 (1 = falling, 0 = rising) in edge mode, the falling edge of the routed line makes the pulse and the rising edge makes none.
- R4: Start select code 0 uses `sw_start`. In edge mode, a one-cycle `sw_start` gives one `start_pulse`, seen after the next clock edge.
- R5: With `start_edge`=0, `start_pulse` follows the selected level XOR `start_pol`, with the same three-edge latency for routed lines.
- R6: Select code 31 is constant low on every path. A start path on code 31 with `start_pol`=0 never pulses, whatever `route_in[31]` does. A gate on code 31 is inactive with `gate_pol`=0 and active with `gate_pol`=1.
- R7: Update select code 0 is internal mode. Each cycle with `timer_tc` high gives one `update_pulse` after the next clock edge, including back-to-back cycles. `upd_pol` has no effect in this mode.
- R8: Any other update code is external mode. The active edge of the selected line (`upd_pol` 0 = rising, 1 = falling) gives one `update_pulse` after the third clock edge.
- R9: With `gate_en`=0, or with `gate_sel`=0, `gate_ok` is 1 whatever the routed lines do.
- R10: With gating on, `gate_pol`=0 makes a high level active and `gate_pol`=1 makes a low level active. `gate_ok` shows the result three clock edges after the line changes.
- R11: An update pulse is produced only in a cycle where `gate_ok` is 1. While the gate is inactive, update events are dropped. Start pulses still occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| route_in | input | 64 | Asynchronous routed trigger lines |
| sw_start | input | 1 | Software start pulse, synchronous to clk |
| timer_tc | input | 1 | Internal update timer terminal count, synchronous |
| start_sel | input | 6 | Start source code (0 software, 31 low) |
| start_pol | input | 1 | Start polarity, 1 inverts |
| start_edge | input | 1 | 1 = edge mode, 0 = level mode |
| upd_sel | input | 6 | Update source code (0 internal timer, 31 low) |
| upd_pol | input | 1 | Update polarity, external mode only |
| gate_en | input | 1 | 1 enables external gating |
| gate_pol | input | 1 | 0 active high, 1 active low |
| gate_sel | input | 6 | Gate source code (0 gating off, 31 low) |
| start_pulse | output | 1 | Conditioned start trigger |
| update_pulse | output | 1 | Conditioned update pulse |
| gate_ok | output | 1 | Gate allows operation |

## Verification
The properties assume that selector, polarity and mode inputs are quasi-static configuration. A change to any of them can create one legitimate spurious edge, so a property such as the single-cycle start pulse is qualified on the edge mode having been held. They also assume that `sw_start` and `timer_tc` are synchronous to the clock. The stimulus changes configuration only inside a settling window in which the scoreboard is muted and its queues are flushed. It drives the synchronous inputs for exactly one cycle per event, and toggles routed lines only once they have settled. Level mode and gate levels are checked directly at the computed cycle instead of through the pulse queues.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int unsigned N_SRC_DEF   = 64;
  localparam int unsigned SEL_W_DEF   = $clog2(N_SRC_DEF);
  localparam int unsigned SYNC_DEF    = 2;
  // Selector codes with fixed meaning on every path
  localparam int unsigned CODE_LOCAL  = 0;
  localparam int unsigned CODE_LOW    = 31;
endpackage

// File: rtl/trg_sync.sv
module trg_sync #(
  parameter int unsigned W      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_d [STAGES];
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stg_d[s] = d;
    end else begin : g_next
      assign stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/trg_src_mux.sv
module trg_src_mux #(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned SEL_W = 6
) (
  input  logic [N_SRC-1:0] vec,
  input  logic [SEL_W-1:0] sel,
  input  logic             local_src,
  output logic             lvl
);
  import trg_pkg::*;

  always_comb begin
    if (sel == SEL_W'(CODE_LOCAL))     lvl = local_src;
    else if (sel == SEL_W'(CODE_LOW))  lvl = 1'b0;
    else                               lvl = vec[sel];
  end
endmodule

// File: rtl/trg_pulse.sv
module trg_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic edge_mode,
  input  logic qual,
  output logic pulse
);
  logic prev_q;
  logic pulse_d, pulse_q;

  always_comb begin
    if (edge_mode) pulse_d = qual & lvl & ~prev_q;
    else           pulse_d = qual & lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= lvl;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/trg_gate.sv
module trg_gate #(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] vec,
  input  logic             en,
  input  logic             pol,
  input  logic [SEL_W-1:0] sel,
  output logic             active,
  output logic             ok
);
  import trg_pkg::*;

  logic src_lvl;
  logic ok_q;

  trg_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
    .vec      (vec),
    .sel      (sel),
    .local_src(1'b0),
    .lvl      (src_lvl)
  );

  always_comb begin
    if (!en || sel == SEL_W'(CODE_LOCAL)) active = 1'b1;
    else                                  active = src_lvl ^ pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b1;
    else        ok_q <= active;
  end

  assign ok = ok_q;
endmodule

// File: rtl/dout_trig_cond.sv
module dout_trig_cond #(
  parameter int unsigned N_SRC = trg_pkg::N_SRC_DEF,
  parameter int unsigned SEL_W = trg_pkg::SEL_W_DEF,
  parameter int unsigned SYNC  = trg_pkg::SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] route_in,
  input  logic             sw_start,
  input  logic             timer_tc,
  input  logic [SEL_W-1:0] start_sel,
  input  logic             start_pol,
  input  logic             start_edge,
  input  logic [SEL_W-1:0] upd_sel,
  input  logic             upd_pol,
  input  logic             gate_en,
  input  logic             gate_pol,
  input  logic [SEL_W-1:0] gate_sel,
  output logic             start_pulse,
  output logic             update_pulse,
  output logic             gate_ok
);
  import trg_pkg::*;

  logic [N_SRC-1:0] route_s;
  logic start_raw, start_lvl;
  logic upd_raw, upd_lvl, upd_internal;
  logic gate_active;

  trg_sync #(.W(N_SRC), .STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (route_in),
    .q    (route_s)
  );

  // Start path: code 0 takes the software pulse
  trg_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_start_mux (
    .vec      (route_s),
    .sel      (start_sel),
    .local_src(sw_start),
    .lvl      (start_raw)
  );

  assign start_lvl = start_raw ^ start_pol;

  trg_pulse u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (start_lvl),
    .edge_mode(start_edge),
    .qual     (1'b1),
    .pulse    (start_pulse)
  );

  // Update path: code 0 is the internal timer, taken as-is with no polarity
  trg_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_upd_mux (
    .vec      (route_s),
    .sel      (upd_sel),
    .local_src(timer_tc),
    .lvl      (upd_raw)
  );

  always_comb begin
    upd_internal = (upd_sel == SEL_W'(CODE_LOCAL));
    if (upd_internal) upd_lvl = upd_raw;
    else              upd_lvl = upd_raw ^ upd_pol;
  end

  trg_gate #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .vec   (route_s),
    .en    (gate_en),
    .pol   (gate_pol),
    .sel   (gate_sel),
    .active(gate_active),
    .ok    (gate_ok)
  );

  trg_pulse u_upd (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (upd_lvl),
    .edge_mode(~upd_internal),
    .qual     (gate_active),
    .pulse    (update_pulse)
  );
endmodule

// File: rtl/dout_trig_cond_chk.sv
module dout_trig_cond_chk #(
  parameter int unsigned SEL_W = trg_pkg::SEL_W_DEF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             timer_tc,
  input logic [SEL_W-1:0] start_sel,
  input logic             start_pol,
  input logic             start_edge,
  input logic [SEL_W-1:0] upd_sel,
  input logic             gate_en,
  input logic [SEL_W-1:0] gate_sel,
  input logic             start_pulse,
  input logic             update_pulse,
  input logic             gate_ok
);
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_edge) && start_edge && start_pulse) |=> !start_pulse);

  // R6
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_sel == SEL_W'(31) && !start_pol) |=> !start_pulse);

  // R7
  upd_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_sel == '0 && timer_tc && !gate_en) |=> update_pulse);

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> gate_ok);

  // R9
  gate_code0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_sel == '0) |=> gate_ok);

  // R11
  upd_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> gate_ok);
endmodule

bind dout_trig_cond dout_trig_cond_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/dout_trig_cond_tb.sv
module dout_trig_cond_tb;
  typedef struct {
    int    cyc;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] route = '0;
  logic        sw_start = 1'b0, timer_tc = 1'b0;
  logic [5:0]  start_sel = '0, upd_sel = '0, gate_sel = '0;
  logic        start_pol = 1'b0, start_edge = 1'b1, upd_pol = 1'b0;
  logic        gate_en = 1'b0, gate_pol = 1'b0;
  logic        start_pulse, update_pulse, gate_ok;

  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  bit   mon_en = 1'b0, mon_start_en = 1'b1;
  exp_t exp_start[$];
  exp_t exp_upd[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dout_trig_cond u_dut (
    .clk(clk), .rst_n(rst_n), .route_in(route), .sw_start(sw_start),
    .timer_tc(timer_tc), .start_sel(start_sel), .start_pol(start_pol),
    .start_edge(start_edge), .upd_sel(upd_sel), .upd_pol(upd_pol),
    .gate_en(gate_en), .gate_pol(gate_pol), .gate_sel(gate_sel),
    .start_pulse(start_pulse), .update_pulse(update_pulse), .gate_ok(gate_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: pops expected pulses and compares them with what the design produces
  always @(negedge clk) begin
    if (mon_en) begin
      if (exp_start.size() > 0 && exp_start[0].cyc < cyc) begin
        chk(1'b0, exp_start[0].req, 0, 1);
        void'(exp_start.pop_front());
      end
      if (start_pulse && mon_start_en) begin
        if (exp_start.size() > 0 && exp_start[0].cyc == cyc) begin
          chk(1'b1, exp_start[0].req, 1, 1);
          void'(exp_start.pop_front());
        end else chk(1'b0, "R2 start", 1, 0);
      end
      if (exp_upd.size() > 0 && exp_upd[0].cyc < cyc) begin
        chk(1'b0, exp_upd[0].req, 0, 1);
        void'(exp_upd.pop_front());
      end
      if (update_pulse) begin
        if (exp_upd.size() > 0 && exp_upd[0].cyc == cyc) begin
          chk(1'b1, exp_upd[0].req, 1, 1);
          void'(exp_upd.pop_front());
        end else chk(1'b0, "R11 update", 1, 0);
      end
    end
  end

  task automatic cfg_mute();
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  task automatic cfg_settle();
    repeat (6) @(negedge clk);
    exp_start.delete();
    exp_upd.delete();
    mon_en = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver tasks: called at a negedge, they push the expected pulse cycle
  task automatic route_set(input int idx, input bit v, input bit e_st, input bit e_up,
                           input string req);
    route[idx] = v;
    if (e_st) exp_start.push_back('{cyc + 3, req});
    if (e_up) exp_upd.push_back('{cyc + 3, req});
    idle(6);
  endtask

  task automatic sw_fire(input bit expect_pulse, input string req);
    sw_start = 1'b1;
    if (expect_pulse) exp_start.push_back('{cyc + 1, req});
    @(negedge clk);
    sw_start = 1'b0;
    idle(4);
  endtask

  task automatic tc_burst(input int n, input bit expect_pulse, input string req);
    for (int i = 0; i < n; i++) begin
      timer_tc = 1'b1;
      if (expect_pulse) exp_upd.push_back('{cyc + 1, req});
      @(negedge clk);
    end
    timer_tc = 1'b0;
    idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(start_pulse == 1'b0, "R1 start", start_pulse, 0);
    chk(update_pulse == 1'b0, "R1 update", update_pulse, 0);
    chk(gate_ok == 1'b1, "R1 gate", gate_ok, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_pulse == 1'b0 && update_pulse == 1'b0 && gate_ok == 1'b1,
        "R1 after release", {start_pulse, update_pulse, gate_ok}, 1);

    // R2 rising edge, external start
    cfg_mute(); start_sel = 6'd5; start_pol = 1'b0; start_edge = 1'b1; cfg_settle();
    route_set(5, 1'b1, 1'b1, 1'b0, "R2 rise");
    idle(6);
    route_set(5, 1'b0, 1'b0, 1'b0, "R2 fall");

    // R3 falling edge in inverted polarity
    cfg_mute(); start_pol = 1'b1; route[5] = 1'b1; cfg_settle();
    route_set(5, 1'b0, 1'b1, 1'b0, "R3 fall");
    route_set(5, 1'b1, 1'b0, 1'b0, "R3 rise");

    // R4 software start
    cfg_mute(); start_sel = 6'd0; start_pol = 1'b0; cfg_settle();
    sw_fire(1'b1, "R4 first");
    sw_fire(1'b1, "R4 second");

    // R7 internal update, upd_pol ignored, back-to-back
    cfg_mute(); upd_sel = 6'd0; upd_pol = 1'b1; cfg_settle();
    tc_burst(3, 1'b1, "R7 burst");
    tc_burst(1, 1'b1, "R7 single");

    // R8 external update, both polarities
    cfg_mute(); upd_sel = 6'd12; upd_pol = 1'b0; cfg_settle();
    route_set(12, 1'b1, 1'b0, 1'b1, "R8 rise");
    route_set(12, 1'b0, 1'b0, 1'b0, "R8 fall ignored");
    cfg_mute(); upd_pol = 1'b1; route[12] = 1'b1; cfg_settle();
    route_set(12, 1'b0, 1'b0, 1'b1, "R8 fall");

    // R10/R11 gate active high, update suppressed, start unaffected
    cfg_mute(); upd_sel = 6'd0; upd_pol = 1'b0; gate_en = 1'b1; gate_sel = 6'd20;
    gate_pol = 1'b0; route[20] = 1'b0; cfg_settle();
    chk(gate_ok == 1'b0, "R10 high-active low", gate_ok, 0);
    tc_burst(2, 1'b0, "R11 suppressed");
    sw_fire(1'b1, "R11 start unaffected");
    route[20] = 1'b1;
    idle(2);
    chk(gate_ok == 1'b0, "R10 latency", gate_ok, 0);
    idle(1);
    chk(gate_ok == 1'b1, "R10 high-active high", gate_ok, 1);
    tc_burst(1, 1'b1, "R11 pass");

    // R10 active low
    cfg_mute(); gate_pol = 1'b1; cfg_settle();
    chk(gate_ok == 1'b0, "R10 low-active high", gate_ok, 0);
    route[20] = 1'b0; idle(4);
    chk(gate_ok == 1'b1, "R10 low-active low", gate_ok, 1);

    // R9 gating off by enable and by code 0
    cfg_mute(); gate_pol = 1'b0; gate_en = 1'b0; cfg_settle();
    chk(gate_ok == 1'b1, "R9 enable off", gate_ok, 1);
    tc_burst(1, 1'b1, "R9 update passes");
    cfg_mute(); gate_en = 1'b1; gate_sel = 6'd0; cfg_settle();
    route[0] = 1'b1; idle(4); route[0] = 1'b0; idle(4);
    chk(gate_ok == 1'b1, "R9 code 0", gate_ok, 1);

    // R6 code 31 is constant low
    cfg_mute(); start_sel = 6'd31; start_pol = 1'b0; start_edge = 1'b1;
    gate_sel = 6'd31; gate_pol = 1'b0; cfg_settle();
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 12; i++) begin
        route[31] = ~route[31];
        @(negedge clk);
        if (start_pulse) seen = 1'b1;
      end
      chk(seen == 1'b0, "R6 start low", seen, 0);
    end
    chk(gate_ok == 1'b0, "R6 gate low pol0", gate_ok, 0);
    cfg_mute(); gate_pol = 1'b1; cfg_settle();
    chk(gate_ok == 1'b1, "R6 gate low pol1", gate_ok, 1);

    // R5 level mode
    cfg_mute(); mon_start_en = 1'b0; start_sel = 6'd7; start_edge = 1'b0; start_pol = 1'b0;
    gate_en = 1'b0; cfg_settle();
    chk(start_pulse == 1'b0, "R5 idle level", start_pulse, 0);
    route[7] = 1'b1;
    idle(2);
    chk(start_pulse == 1'b0, "R5 latency", start_pulse, 0);
    idle(1);
    chk(start_pulse == 1'b1, "R5 follows", start_pulse, 1);
    idle(5);
    chk(start_pulse == 1'b1, "R5 holds", start_pulse, 1);
    cfg_mute(); start_pol = 1'b1; cfg_settle();
    chk(start_pulse == 1'b0, "R5 inverted", start_pulse, 0);
    route[7] = 1'b0; idle(4);
    chk(start_pulse == 1'b1, "R5 inverted low", start_pulse, 1);

    idle(6);
    mon_en = 1'b0;
    foreach (exp_start[i]) chk(1'b0, exp_start[i].req, 0, 1);
    foreach (exp_upd[i]) chk(1'b0, exp_upd[i].req, 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=0 (cycle limit)", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule